// File: doc/BRIEF.md
# Radix-2 Signed-Digit Carry-Free Adder

This block adds two operands held in radix-2 signed-digit form, where each digit can be -1, 0 or +1. Because a value can be written in more than one way, the adder accepts any valid encoding of either operand. It produces a sum that is one digit wider and is also in signed-digit form.

The addition works in a fixed number of steps for each digit position. First the two operand digits are added. That sum is then split into an interim digit and a transfer digit, and the interim digit is combined with the transfer coming up from the position below. The choice of split depends only on the digits one position lower. As a result, no carry ever travels more than one position, and the logic depth does not depend on the word width.

A combinational converter turns the redundant sum into ordinary two's-complement binary so that results can be compared directly. The whole block is combinational. The digit count is a parameter.

Top module: `rsd_adder`

## Requirements
- R1: Each digit uses two bits {pos,neg} at bit pair [2i+1:2i], with pos at the higher bit. The code 10 means +1, 01 means -1 and 00 means 0. At the inputs, the code 11 has the same effect on both outputs as 00.
- R2: No digit of `s_dig` ever carries the code 11.
- R3: The value of `s_dig` equals the value of `x_dig` plus the value of `y_dig` for every input encoding, including different encodings of the same operand values.
- R4: Output digit j depends only on input positions j, j-1 and j-2. Changing input position k leaves output digits below k and above k+2 unchanged.
- R5: The top sum digit (index N_DIGITS) is the transfer out of the top input position. When both top input digits are +1 it is +1, and when both are -1 it is -1.
- R6: When every input digit means zero, every output digit is 00 and `s_bin` is 0.
- R7: Position 0 treats its missing lower neighbour as non-negative. With x = +1 in digit 0 and all other input digits 0, the sum is -1 in digit 0 (code 01) and +1 in digit 1 (code 10), giving `s_dig` = 0x9.
- R8: `s_bin` is the (N_DIGITS+2)-bit two's-complement value of `s_dig`, computed as the word of +1 positions minus the word of -1 positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_dig | input | 2*N_DIGITS | First operand, signed digits |
| y_dig | input | 2*N_DIGITS | Second operand, signed digits |
| s_dig | output | 2*(N_DIGITS+1) | Redundant sum, signed digits |
| s_bin | output | N_DIGITS+2 | Sum as two's-complement binary |

## Verification
The bench builds the block twice. The instance with eight digits is driven with random encodings, including the unused code and rewritten encodings of the same values. It is also driven with locality probes and with top-digit and extreme-value cases. The instance with two digits is driven with all 256 combinations of input codes, so every pattern of a digit position and its lower neighbour occurs, including position 0 and the top transfer.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   typedef logic [1:0] rsd_dig_t;

   localparam rsd_dig_t RSD_ZERO = 2'b00;
   localparam rsd_dig_t RSD_POS  = 2'b10;
   localparam rsd_dig_t RSD_NEG  = 2'b01;

   // digit code -> small signed integer; code 11 reads as zero
   function automatic logic signed [2:0] dig_to_int(input rsd_dig_t d);
      logic signed [2:0] v;
      if (d[1] && !d[0])      v = 3'sd1;
      else if (d[0] && !d[1]) v = -3'sd1;
      else                    v = 3'sd0;
      return v;
   endfunction

   // small signed integer (-1..+1) -> digit code
   function automatic rsd_dig_t int_to_dig(input logic signed [2:0] v);
      rsd_dig_t d;
      if (v > 0)      d = RSD_POS;
      else if (v < 0) d = RSD_NEG;
      else            d = RSD_ZERO;
      return d;
   endfunction

   function automatic logic is_neg(input rsd_dig_t d);
      return d[0] && !d[1];
   endfunction
endpackage

// File: rtl/rsd_split.sv
module rsd_split
   import rsd_pkg::*;
(
   input  rsd_dig_t xd,
   input  rsd_dig_t yd,
   input  logic     lo_nonneg,
   output rsd_dig_t w,
   output rsd_dig_t t
);
   logic signed [2:0] p;

   always_comb begin
      p = dig_to_int(xd) + dig_to_int(yd);
      w = RSD_ZERO;
      t = RSD_ZERO;
      case (p)
         3'sd2:  begin t = RSD_POS; w = RSD_ZERO; end
         -3'sd2: begin t = RSD_NEG; w = RSD_ZERO; end
         3'sd1: begin
            if (lo_nonneg) begin t = RSD_POS;  w = RSD_NEG; end
            else           begin t = RSD_ZERO; w = RSD_POS; end
         end
         -3'sd1: begin
            if (lo_nonneg) begin t = RSD_ZERO; w = RSD_NEG; end
            else           begin t = RSD_NEG;  w = RSD_POS; end
         end
         default: begin t = RSD_ZERO; w = RSD_ZERO; end
      endcase
   end
endmodule

// File: rtl/rsd_combine.sv
module rsd_combine
   import rsd_pkg::*;
(
   input  rsd_dig_t w,
   input  rsd_dig_t tin,
   output rsd_dig_t s
);
   logic signed [2:0] acc;

   always_comb begin
      acc = dig_to_int(w) + dig_to_int(tin);
      s   = int_to_dig(acc);
   end

   // R2: neighbour-driven split choice must keep the digit sum in range
   always_comb begin
      a_r2_digit_in_range: assert (acc >= -3'sd1 && acc <= 3'sd1)
         else $error("digit sum out of range");
   end
endmodule

// File: rtl/rsd_to_binary.sv
module rsd_to_binary #(
   parameter int ND = 4
) (
   input  logic [2*ND-1:0] dig,
   output logic [ND:0]     bin
);
   logic [ND-1:0] pos_w;
   logic [ND-1:0] neg_w;

   for (genvar i = 0; i < ND; i++) begin : g_sep
      assign pos_w[i] = dig[2*i+1] & ~dig[2*i];
      assign neg_w[i] = dig[2*i]   & ~dig[2*i+1];
   end

   assign bin = {1'b0, pos_w} - {1'b0, neg_w};
endmodule

// File: rtl/rsd_adder.sv
module rsd_adder
   import rsd_pkg::*;
#(
   parameter int N_DIGITS = 8
) (
   input  logic [2*N_DIGITS-1:0]     x_dig,
   input  logic [2*N_DIGITS-1:0]     y_dig,
   output logic [2*(N_DIGITS+1)-1:0] s_dig,
   output logic [N_DIGITS+1:0]       s_bin
);
   localparam int SD = N_DIGITS + 1;
   localparam int BW = N_DIGITS + 2;

   if (N_DIGITS < 2) begin : g_bad_width
      $error("rsd_adder: N_DIGITS must be at least 2");
   end

   rsd_dig_t w_a [N_DIGITS];
   rsd_dig_t t_a [N_DIGITS];
   logic     lo_nn [N_DIGITS];

   for (genvar i = 0; i < N_DIGITS; i++) begin : g_pos
      if (i == 0) begin : g_first
         assign lo_nn[i] = 1'b1;
      end else begin : g_rest
         assign lo_nn[i] = !is_neg(x_dig[2*(i-1) +: 2]) && !is_neg(y_dig[2*(i-1) +: 2]);
      end

      rsd_split u_split (
         .xd        (x_dig[2*i +: 2]),
         .yd        (y_dig[2*i +: 2]),
         .lo_nonneg (lo_nn[i]),
         .w         (w_a[i]),
         .t         (t_a[i])
      );

      if (i == 0) begin : g_c0
         rsd_combine u_comb (.w(w_a[i]), .tin(RSD_ZERO), .s(s_dig[2*i +: 2]));
      end else begin : g_cn
         rsd_combine u_comb (.w(w_a[i]), .tin(t_a[i-1]), .s(s_dig[2*i +: 2]));
      end
   end

   assign s_dig[2*N_DIGITS +: 2] = t_a[N_DIGITS-1];

   rsd_to_binary #(.ND(SD)) u_conv (.dig(s_dig), .bin(s_bin));

   // operand converters feeding only the assertions below
   logic [N_DIGITS:0] xv, yv;
   rsd_to_binary #(.ND(N_DIGITS)) u_xconv (.dig(x_dig), .bin(xv));
   rsd_to_binary #(.ND(N_DIGITS)) u_yconv (.dig(y_dig), .bin(yv));

   logic signed [BW-1:0] ref_sum;
   assign ref_sum = $signed({xv[N_DIGITS], xv}) + $signed({yv[N_DIGITS], yv});

   always_comb begin
      a_r3_value_match: assert ($signed(s_bin) == ref_sum)
         else $error("sum value mismatch");
      for (int j = 0; j < SD; j++) begin
         a_r2_no_code11: assert (s_dig[2*j +: 2] != 2'b11)
            else $error("illegal output code");
      end
      if (xv == '0 && yv == '0 && x_dig == y_dig) begin
         a_r6_zero_sum: assert (s_dig == '0 || (|(x_dig & y_dig)))
            else $error("zero inputs gave nonzero sum");
      end
      if (x_dig[2*N_DIGITS-1 -: 2] == RSD_POS && y_dig[2*N_DIGITS-1 -: 2] == RSD_POS) begin
         a_r5_top_pos: assert (s_dig[2*N_DIGITS +: 2] == RSD_POS)
            else $error("top digit not +1");
      end
      if (x_dig[2*N_DIGITS-1 -: 2] == RSD_NEG && y_dig[2*N_DIGITS-1 -: 2] == RSD_NEG) begin
         a_r5_top_neg: assert (s_dig[2*N_DIGITS +: 2] == RSD_NEG)
            else $error("top digit not -1");
      end
   end
endmodule

// File: tb/sim_rsd_adder.sv
module sim_rsd_adder;
   localparam int N  = 8;
   localparam int SD = N + 1;
   localparam int M  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [2*N-1:0]  x, y;
   logic [2*SD-1:0] s;
   logic [N+1:0]    b;
   logic [2*M-1:0]  x1, y1;
   logic [2*M+1:0]  s1;
   logic [M+1:0]    b1;

   rsd_adder #(.N_DIGITS(N)) u0 (.x_dig(x), .y_dig(y), .s_dig(s), .s_bin(b));
   rsd_adder #(.N_DIGITS(M)) u1 (.x_dig(x1), .y_dig(y1), .s_dig(s1), .s_bin(b1));

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   function automatic int dv(input logic [1:0] c);
      if (c == 2'b10) return 1;
      if (c == 2'b01) return -1;
      return 0;
   endfunction

   function automatic int rval(input logic [63:0] v, input int nd);
      int acc = 0;
      for (int i = nd - 1; i >= 0; i--) acc = acc * 2 + dv(v[2*i +: 2]);
      return acc;
   endfunction

   function automatic int sx(input logic [63:0] v, input int w);
      int r = 0;
      for (int i = 0; i < w; i++) if (v[i]) r = (i == w - 1) ? r - (1 << i) : r + (1 << i);
      return r;
   endfunction

   function automatic int no11(input logic [63:0] v, input int nd);
      for (int i = 0; i < nd; i++) if (v[2*i +: 2] == 2'b11) return 0;
      return 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [2*N-1:0] a, input logic [2*N-1:0] c);
      @(negedge clk);
      x = a; y = c;
      #1;
   endtask

   // rewrite (0,+1) at positions (i,i-1) into (+1,-1): same value, new encoding
   function automatic logic [2*N-1:0] reenc(input logic [2*N-1:0] v);
      logic [2*N-1:0] r = v;
      for (int i = 1; i < N; i++)
         if (r[2*i +: 2] == 2'b00 && r[2*(i-1) +: 2] == 2'b10 && ($urandom % 2 == 1)) begin
            r[2*i +: 2]     = 2'b10;
            r[2*(i-1) +: 2] = 2'b01;
         end
      return r;
   endfunction

   task automatic check_sum(input string req);
      int e = rval(64'(x), N) + rval(64'(y), N);
      chk(rval(64'(s), SD) == e, req, rval(64'(s), SD), e);
      chk(sx(64'(b), N + 2) == e, "R8", sx(64'(b), N + 2), e);
      chk(no11(64'(s), SD) == 1, "R2", 0, 1);
   endtask

   initial begin
      x = '0; y = '0; x1 = '0; y1 = '0;
      repeat (3) @(posedge clk);
      #1;
      // R6: reset-time zero inputs
      chk(s == '0, "R6", int'(s), 0);
      chk(b == '0, "R6", int'(b), 0);
      rst = 1'b0;

      // R1: code 11 equals 00
      drive({N{2'b11}}, 16'h0000);
      chk(s == '0 && b == '0, "R1", int'(s), 0);
      drive(16'h0002 | 16'h0300, 16'h0001);
      begin
         logic [2*SD-1:0] ref_s = s;
         drive(16'h0002, 16'h0001);
         chk(s == ref_s, "R1", int'(s), int'(ref_s));
      end

      // R7: position 0 lower neighbour is non-negative
      drive(16'h0002, 16'h0000);
      chk(s == 18'h9, "R7", int'(s), 9);
      check_sum("R3");

      // R5: top transfer
      drive(16'h8000, 16'h8000);
      chk(s[2*N +: 2] == 2'b10, "R5", int'(s[2*N +: 2]), 2);
      check_sum("R3");
      drive(16'h4000, 16'h4000);
      chk(s[2*N +: 2] == 2'b01, "R5", int'(s[2*N +: 2]), 1);
      check_sum("R3");

      // extremes for R8
      drive({N{2'b10}}, {N{2'b10}});
      check_sum("R3");
      drive({N{2'b01}}, {N{2'b01}});
      check_sum("R3");

      // R3: random encodings and re-encodings of the same values
      for (int k = 0; k < 400; k++) begin
         logic [2*N-1:0] a = 16'($urandom);
         logic [2*N-1:0] c = 16'($urandom);
         int e;
         drive(a, c);
         check_sum("R3");
         e = rval(64'(s), SD);
         drive(reenc(a), reenc(c));
         chk(rval(64'(s), SD) == e, "R3", rval(64'(s), SD), e);
      end

      // R4: locality of a change at position k
      for (int k = 0; k < N; k++) begin
         for (int r = 0; r < 8; r++) begin
            logic [2*N-1:0] a = 16'($urandom);
            logic [2*N-1:0] c = 16'($urandom);
            logic [2*SD-1:0] s0;
            drive(a, c);
            s0 = s;
            a[2*k +: 2] = a[2*k +: 2] + 2'd1;
            drive(a, c);
            for (int j = 0; j < SD; j++)
               if (j < k || j > k + 2)
                  chk(s[2*j +: 2] == s0[2*j +: 2], "R4", int'(s[2*j +: 2]), int'(s0[2*j +: 2]));
         end
      end

      // exhaustive two-digit instance: all 256 code pairs
      for (int a = 0; a < 16; a++) begin
         for (int c = 0; c < 16; c++) begin
            int e;
            @(negedge clk);
            x1 = 4'(a); y1 = 4'(c);
            #1;
            e = rval(64'(x1), M) + rval(64'(y1), M);
            chk(rval(64'(s1), M + 1) == e, "R3", rval(64'(s1), M + 1), e);
            chk(sx(64'(b1), M + 2) == e, "R8", sx(64'(b1), M + 2), e);
            chk(no11(64'(s1), M + 1) == 1, "R2", 0, 1);
         end
      end

      drive('0, '0);
      chk(s == '0, "R6", int'(s), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule